// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block drives the control lines of a multicycle processor datapath from a small microcode store. A 4-bit micro-program counter selects one of ten microinstructions. Each microinstruction holds seven functional fields: ALU operation, first operand source, second operand source, register-file action, memory action, PC-update action and next-address selection. A field decoder turns the current word into the individual datapath control lines. These lines depend only on the current micro-address, so the block behaves as a Moore machine.

The next micro-address comes from the 2-bit sequencing field. The field can step to the next word, go back to the fetch word, or branch through one of two opcode-indexed dispatch tables. The datapath holds the 6-bit opcode of the instruction in flight steady on `opcode` while that instruction runs. All outputs are plain level signals with no handshake. The datapath samples them on the same rising edge that moves the micro-PC on.

Top module: `ucseq_top`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 (the fetch word). Reset is asynchronous, so `upc` goes to 0 as soon as `rst_n` falls, even in the middle of an instruction.
- R2: A word whose sequencing field is "next" (micro-addresses 0, 3 and 6) moves `upc` to its own address plus one at the next rising edge.
- R3: A word whose sequencing field is "fetch" (micro-addresses 4, 5, 7, 8 and 9) moves `upc` to 0 at the next rising edge.
- R4: The decode word (address 1) dispatches through the first table. Opcode 6'h00 (register op) goes to 6, 6'h02 (jump) goes to 9, 6'h04 (branch-equal) goes to 8, and both 6'h23 (load) and 6'h2B (store) go to 2.
- R5: The address word (address 2) dispatches through the second table. Opcode 6'h23 goes to 3 and 6'h2B goes to 5.
- R6: An opcode that is missing from the table in use sends `upc` to 0.
- R7: `upc` never leaves the range 0 to 9.
- R8: At address 0 the outputs are as follows: `pc_load`, `mem_rd` and `ir_load` are 1, `srcb_sel` is 2'b01 (constant four), `alu_op` is 2'b00 (add), `pc_src` is 2'b00, and every other output is 0.
- R9: `mem_rd` and `mem_wr` are never both 1. `pc_load` and `pc_load_if_zero` are never both 1. `reg_wr` is 1 only at address 4 (with `wb_from_mem`=1) or address 7 (with `dst_from_rd`=1).
- R10: Counting from fetch, a load takes 5 cycles, a store 4, a register op 4, a branch-equal 3, a jump 3 and an unknown opcode 2.
- R11: At address 8 the outputs are as follows: `alu_op` is 2'b01 (subtract), `srca_reg` is 1, `srcb_sel` is 2'b00, `pc_load_if_zero` is 1, `pc_src` is 2'b01, and all others are 0.
- R12: The other words drive these outputs, with every unlisted output 0:
  - At address 9: `pc_load`=1 and `pc_src`=2'b10.
  - At address 1: `srcb_sel`=2'b11.
  - At address 2: `srca_reg`=1 and `srcb_sel`=2'b10.
  - At address 6: `srca_reg`=1 and `alu_op`=2'b10.
  - At addresses 3 and 5: `addr_from_alu`=1, with `mem_rd` or `mem_wr` set respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode of the instruction being executed |
| upc | output | 4 | Current micro-address |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_zero | output | 1 | PC write when the ALU zero flag is set |
| addr_from_alu | output | 1 | Memory address from ALU result register, else PC |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register |
| dst_from_rd | output | 1 | Destination register from the rd field, else rt |
| reg_wr | output | 1 | Register file write |
| srca_reg | output | 1 | ALU operand A from register A, else PC |
| srcb_sel | output | 2 | ALU operand B: 00 reg B, 01 four, 10 immediate, 11 immediate shifted |
| alu_op | output | 2 | 00 add, 01 subtract, 10 decode function field |
| pc_src | output | 2 | 00 ALU result, 01 ALU result register, 10 jump address |

## Verification
The assertions assume that `opcode` stays steady for the whole of an instruction, from the fetch word until `upc` returns to 0. The dispatch checks depend on the opcode value at the decode and address words. The stimulus changes `opcode` only on a falling edge while `upc` is 0. The values come from a fixed-seed generator that favours the five defined opcodes and also produces arbitrary 6-bit codes. Directed cases add the opcode neighbours of the defined codes and a reset in the middle of an instruction.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int UPC_W       = 4;
  localparam int OP_W        = 6;
  localparam int UCODE_DEPTH = 10;

  typedef enum logic [1:0] {SQ_NEXT = 2'b00, SQ_FETCH = 2'b01, SQ_DISP1 = 2'b10, SQ_DISP2 = 2'b11} seq_e;
  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNCT = 2'b10} alu_e;
  typedef enum logic [1:0] {SB_REG = 2'b00, SB_FOUR = 2'b01, SB_IMM = 2'b10, SB_IMMSH = 2'b11} srcb_e;
  typedef enum logic [1:0] {RG_NONE = 2'b00, RG_READ = 2'b01, RG_WR_ALU = 2'b10, RG_WR_MDR = 2'b11} regc_e;
  typedef enum logic [1:0] {MM_NONE = 2'b00, MM_FETCH = 2'b01, MM_RD_ALU = 2'b10, MM_WR_ALU = 2'b11} memc_e;
  typedef enum logic [1:0] {PW_NONE = 2'b00, PW_ALU = 2'b01, PW_COND = 2'b10, PW_JUMP = 2'b11} pcw_e;

  typedef struct packed {
    alu_e  alu;
    logic  src1;
    srcb_e src2;
    regc_e regc;
    memc_e memc;
    pcw_e  pcw;
    seq_e  seq;
  } uinstr_t;

  localparam logic [UPC_W-1:0] UA_FETCH   = UPC_W'(0);
  localparam logic [UPC_W-1:0] UA_DECODE  = UPC_W'(1);
  localparam logic [UPC_W-1:0] UA_MEMADDR = UPC_W'(2);
  localparam logic [UPC_W-1:0] UA_LDRD    = UPC_W'(3);
  localparam logic [UPC_W-1:0] UA_LDWB    = UPC_W'(4);
  localparam logic [UPC_W-1:0] UA_STWR    = UPC_W'(5);
  localparam logic [UPC_W-1:0] UA_REXE    = UPC_W'(6);
  localparam logic [UPC_W-1:0] UA_RWB     = UPC_W'(7);
  localparam logic [UPC_W-1:0] UA_BEQ     = UPC_W'(8);
  localparam logic [UPC_W-1:0] UA_JMP     = UPC_W'(9);

  localparam logic [OP_W-1:0] OPC_RTYPE = OP_W'(6'h00);
  localparam logic [OP_W-1:0] OPC_JMP   = OP_W'(6'h02);
  localparam logic [OP_W-1:0] OPC_BEQ   = OP_W'(6'h04);
  localparam logic [OP_W-1:0] OPC_LOAD  = OP_W'(6'h23);
  localparam logic [OP_W-1:0] OPC_STORE = OP_W'(6'h2B);
endpackage

// File: rtl/ucseq_rom.sv
module ucseq_rom
  import ucseq_pkg::*;
(
  input  logic [UPC_W-1:0] addr,
  output uinstr_t          word
);
  function automatic uinstr_t mk(alu_e a, logic s1, srcb_e s2, regc_e r, memc_e m, pcw_e p, seq_e q);
    uinstr_t w;
    w.alu = a; w.src1 = s1; w.src2 = s2; w.regc = r; w.memc = m; w.pcw = p; w.seq = q;
    return w;
  endfunction

  always_comb begin
    unique case (addr)
      UA_FETCH:   word = mk(ALU_ADD,   1'b0, SB_FOUR,  RG_NONE,   MM_FETCH,  PW_ALU,  SQ_NEXT);
      UA_DECODE:  word = mk(ALU_ADD,   1'b0, SB_IMMSH, RG_READ,   MM_NONE,   PW_NONE, SQ_DISP1);
      UA_MEMADDR: word = mk(ALU_ADD,   1'b1, SB_IMM,   RG_NONE,   MM_NONE,   PW_NONE, SQ_DISP2);
      UA_LDRD:    word = mk(ALU_ADD,   1'b0, SB_REG,   RG_NONE,   MM_RD_ALU, PW_NONE, SQ_NEXT);
      UA_LDWB:    word = mk(ALU_ADD,   1'b0, SB_REG,   RG_WR_MDR, MM_NONE,   PW_NONE, SQ_FETCH);
      UA_STWR:    word = mk(ALU_ADD,   1'b0, SB_REG,   RG_NONE,   MM_WR_ALU, PW_NONE, SQ_FETCH);
      UA_REXE:    word = mk(ALU_FUNCT, 1'b1, SB_REG,   RG_NONE,   MM_NONE,   PW_NONE, SQ_NEXT);
      UA_RWB:     word = mk(ALU_ADD,   1'b0, SB_REG,   RG_WR_ALU, MM_NONE,   PW_NONE, SQ_FETCH);
      UA_BEQ:     word = mk(ALU_SUB,   1'b1, SB_REG,   RG_NONE,   MM_NONE,   PW_COND, SQ_FETCH);
      UA_JMP:     word = mk(ALU_ADD,   1'b0, SB_REG,   RG_NONE,   MM_NONE,   PW_JUMP, SQ_FETCH);
      default:    word = mk(ALU_ADD,   1'b0, SB_REG,   RG_NONE,   MM_NONE,   PW_NONE, SQ_FETCH);
    endcase
  end
endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
  import ucseq_pkg::*;
#(
  parameter int TBL = 1
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] target,
  output logic             hit
);
  generate
    if (TBL == 1) begin : g_tbl1
      always_comb begin
        hit = 1'b1;
        unique case (opcode)
          OPC_RTYPE: target = UA_REXE;
          OPC_JMP:   target = UA_JMP;
          OPC_BEQ:   target = UA_BEQ;
          OPC_LOAD,
          OPC_STORE: target = UA_MEMADDR;
          default: begin
            target = UA_FETCH;
            hit    = 1'b0;
          end
        endcase
      end
    end else begin : g_tbl2
      always_comb begin
        hit = 1'b1;
        unique case (opcode)
          OPC_LOAD:  target = UA_LDRD;
          OPC_STORE: target = UA_STWR;
          default: begin
            target = UA_FETCH;
            hit    = 1'b0;
          end
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ucseq_decode.sv
module ucseq_decode
  import ucseq_pkg::*;
(
  input  uinstr_t    word,
  output logic       pc_load,
  output logic       pc_load_if_zero,
  output logic       addr_from_alu,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_load,
  output logic       wb_from_mem,
  output logic       dst_from_rd,
  output logic       reg_wr,
  output logic       srca_reg,
  output logic [1:0] srcb_sel,
  output logic [1:0] alu_op,
  output logic [1:0] pc_src
);
  assign alu_op   = word.alu;
  assign srca_reg = word.src1;
  assign srcb_sel = word.src2;

  always_comb begin
    reg_wr = 1'b0; wb_from_mem = 1'b0; dst_from_rd = 1'b0;
    unique case (word.regc)
      RG_WR_ALU: begin reg_wr = 1'b1; dst_from_rd = 1'b1; end
      RG_WR_MDR: begin reg_wr = 1'b1; wb_from_mem = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    mem_rd = 1'b0; mem_wr = 1'b0; ir_load = 1'b0; addr_from_alu = 1'b0;
    unique case (word.memc)
      MM_FETCH:  begin mem_rd = 1'b1; ir_load = 1'b1; end
      MM_RD_ALU: begin mem_rd = 1'b1; addr_from_alu = 1'b1; end
      MM_WR_ALU: begin mem_wr = 1'b1; addr_from_alu = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    pc_load = 1'b0; pc_load_if_zero = 1'b0; pc_src = 2'b00;
    unique case (word.pcw)
      PW_ALU:  pc_load = 1'b1;
      PW_COND: begin pc_load_if_zero = 1'b1; pc_src = 2'b01; end
      PW_JUMP: begin pc_load = 1'b1; pc_src = 2'b10; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ucseq_top.sv
module ucseq_top
  import ucseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] upc,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             addr_from_alu,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_load,
  output logic             wb_from_mem,
  output logic             dst_from_rd,
  output logic             reg_wr,
  output logic             srca_reg,
  output logic [1:0]       srcb_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src
);
  localparam int NTBL = 2;

  logic [UPC_W-1:0] upc_q, upc_nxt;
  uinstr_t          uword;
  logic [UPC_W-1:0] tgt [NTBL];
  logic [NTBL-1:0]  hit;

  ucseq_rom u_rom (.addr(upc_q), .word(uword));

  for (genvar t = 0; t < NTBL; t++) begin : g_disp
    ucseq_dispatch #(.TBL(t + 1)) u_disp (.opcode(opcode), .target(tgt[t]), .hit(hit[t]));
  end

  always_comb begin
    unique case (uword.seq)
      SQ_NEXT:  upc_nxt = upc_q + UPC_W'(1);
      SQ_DISP1: upc_nxt = tgt[0];
      SQ_DISP2: upc_nxt = tgt[1];
      default:  upc_nxt = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= UA_FETCH;
    else        upc_q <= upc_nxt;
  end

  assign upc = upc_q;

  ucseq_decode u_dec (
    .word(uword), .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .wb_from_mem(wb_from_mem), .dst_from_rd(dst_from_rd), .reg_wr(reg_wr),
    .srca_reg(srca_reg), .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  assert_upc_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upc_q < UPC_W'(UCODE_DEPTH));
  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uword.seq == SQ_NEXT |=> upc_q == UPC_W'($past(upc_q) + UPC_W'(1)));
  assert_fetch_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uword.seq == SQ_FETCH |=> upc_q == UA_FETCH);
  assert_disp1_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uword.seq == SQ_DISP1 && !hit[0]) |=> upc_q == UA_FETCH);
  assert_disp2_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uword.seq == SQ_DISP2 && !hit[1]) |=> upc_q == UA_FETCH);
  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_pc_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_load && pc_load_if_zero));
  assert_regwr_place_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (upc_q == UA_LDWB || upc_q == UA_RWB));
endmodule

// File: tb/sim_ucseq_top.sv
module sim_ucseq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [3:0] upc;
  logic pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, ir_load;
  logic wb_from_mem, dst_from_rd, reg_wr, srca_reg;
  logic [1:0] srcb_sel, alu_op, pc_src;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucseq_top u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc), .pc_load(pc_load),
    .pc_load_if_zero(pc_load_if_zero), .addr_from_alu(addr_from_alu), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ir_load(ir_load), .wb_from_mem(wb_from_mem), .dst_from_rd(dst_from_rd),
    .reg_wr(reg_wr), .srca_reg(srca_reg), .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_src(pc_src)
  );

  wire [15:0] ctrl = {pc_load, pc_load_if_zero, addr_from_alu, mem_rd, mem_wr, ir_load,
                      wb_from_mem, dst_from_rd, reg_wr, srca_reg, srcb_sel, alu_op, pc_src};

  function automatic logic [15:0] exp_ctrl(int s);
    logic pl = 0, pz = 0, af = 0, mr = 0, mw = 0, il = 0, wm = 0, dr = 0, rw = 0, sa = 0;
    logic [1:0] sb = 0, ao = 0, ps = 0;
    case (s)
      0: begin pl = 1; mr = 1; il = 1; sb = 2'b01; end
      1: sb = 2'b11;
      2: begin sa = 1; sb = 2'b10; end
      3: begin af = 1; mr = 1; end
      4: begin rw = 1; wm = 1; end
      5: begin af = 1; mw = 1; end
      6: begin sa = 1; ao = 2'b10; end
      7: begin rw = 1; dr = 1; end
      8: begin sa = 1; ao = 2'b01; pz = 1; ps = 2'b01; end
      9: begin pl = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pl, pz, af, mr, mw, il, wm, dr, rw, sa, sb, ao, ps};
  endfunction

  function automatic int exp_next(int s, logic [5:0] op);
    case (s)
      0, 3, 6: return s + 1;
      1: case (op) 6'h00: return 6; 6'h02: return 9; 6'h04: return 8;
                   6'h23, 6'h2B: return 2; default: return 0; endcase
      2: case (op) 6'h23: return 3; 6'h2B: return 5; default: return 0; endcase
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(logic [5:0] op);
    case (op) 6'h23: return 5; 6'h2B, 6'h00: return 4; 6'h04, 6'h02: return 3; default: return 2; endcase
  endfunction

  function automatic string step_tag(int prev, logic [5:0] op);
    if (prev == 0 || prev == 3 || prev == 6) return "R2";
    if (prev == 1) return (exp_next(1, op) == 0) ? "R6" : "R4";
    if (prev == 2) return (exp_next(2, op) == 0) ? "R6" : "R5";
    return "R3";
  endfunction

  function automatic string ctrl_tag(int s);
    if (s == 0) return "R8";
    if (s == 8) return "R11";
    if (s == 4 || s == 7) return "R9";
    return "R12";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_instr(logic [5:0] op);
    int s = 0;
    int n = 0;
    int prev;
    opcode = op;
    #1;
    check(upc == 4'd0, "R3", "start address", upc, 0);
    do begin
      check(ctrl == exp_ctrl(s), ctrl_tag(s), "control vector", ctrl, exp_ctrl(s));
      check(upc < 4'd10, "R7", "micro-address range", upc, s);
      prev = s;
      s = exp_next(s, op);
      @(negedge clk); #1;
      n++;
      check(upc == 4'(s), step_tag(prev, op), "next micro-address", upc, s);
    end while (s != 0 && n < 10);
    check(n == exp_len(op), "R10", "instruction cycle count", n, exp_len(op));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] pick [5] = '{6'h00, 6'h02, 6'h04, 6'h23, 6'h2B};
    logic [5:0] op;
    int r;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    #1;
    check(upc == 4'd0, "R1", "reset micro-address", upc, 0);
    check(ctrl == exp_ctrl(0), "R1", "reset controls", ctrl, exp_ctrl(0));
    @(negedge clk);
    rst_n = 1'b1;
    foreach (pick[i]) run_instr(pick[i]);
    run_instr(6'h3F);
    run_instr(6'h01);
    run_instr(6'h22);
    run_instr(6'h2A);
    run_instr(6'h05);
    opcode = 6'h23;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(upc == 4'd0, "R1", "async reset mid-instruction", upc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 80; k++) begin
      r = $urandom % 8;
      op = (r < 5) ? pick[r] : 6'($urandom);
      run_instr(op);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule